// File: doc/BRIEF.md
# Timer capture/compare channel flags

This block is a single capture/compare channel that sits beside a free-running timer counter. It does not count by itself. It watches the counter value, the reload value, the counting mode and the overflow and underflow pulses that the counter supplies. It then keeps one shared channel register, a channel status flag that can raise an interrupt, and an overcapture flag.

In input mode the external signal passes through a two-flop synchronizer. An edge of the chosen polarity latches the current count into the channel register and raises the status flag. If the status flag is still set from an earlier capture when a new capture arrives, the overcapture flag is also raised. In output mode software loads the channel register as a compare value, and the status flag is raised when the count equals it. If the compare value lies above the reload value, the count can never reach it, so the flag is raised on the wrap event of the active counting mode instead.

Software clears a flag by writing 0 to its bit in a clear strobe. In input mode, a read strobe of the channel register also clears the status flag.

Top module: `ccflag_channel`

## Requirements
- R1: After reset, `flag`, `ovc_flag`, `irq` and `reg_q` are all 0.
- R2: In input mode (`in_mode`=1), an edge on `sig_in` of the selected polarity (`fall_sel`=0 rising, 1 falling) copies `cnt` into `reg_q` and sets `flag`. The first clock edge that samples the new level is edge k. The copied value is `cnt` at edge k+2, and both results are visible after edge k+2. An edge of the other polarity changes nothing.
- R3: In input mode, a `reg_rd` pulse clears `flag`. In output mode `reg_rd` leaves `flag` unchanged.
- R4: `ovc_flag` is set by a capture that occurs while `flag` is already 1. It is never set in output mode.
- R5: Only a clear strobe (`clr_wr`=1) with `clr_data[1]`=0 clears `ovc_flag`. `reg_rd` does not clear it.
- R6: In output mode, `flag` is set one clock after a cycle in which `cnt` equals `reg_q`.
- R7: In output mode with `reg_q` > `arr`, `flag` is set one clock after an `ovf` pulse when `cnt_mode` is 0 (up) or 2 (up/down). It is set after a `unf` pulse when `cnt_mode` is 1 (down). A wrap pulse of the other kind has no effect.
- R8: A clear strobe with `clr_data[0]`=0 clears `flag`. Writing 1 to either bit has no effect. If a set and a clear fall in the same cycle, the flag ends up 1.
- R9: `irq` equals `flag` AND `ie` at all times.
- R10: `reg_wr` loads `reg_wdata` into `reg_q` only in output mode. In input mode it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | CW | Current counter value |
| arr | input | CW | Counter reload value |
| cnt_mode | input | 2 | 0 up, 1 down, 2 up/down |
| ovf | input | 1 | Counter overflow pulse |
| unf | input | 1 | Counter underflow pulse |
| sig_in | input | 1 | Asynchronous capture input |
| fall_sel | input | 1 | Capture polarity: 0 rising, 1 falling |
| in_mode | input | 1 | 1 input capture, 0 output compare |
| ie | input | 1 | Interrupt enable |
| reg_wr | input | 1 | Write strobe for the compare value |
| reg_wdata | input | CW | Compare value to write |
| reg_rd | input | 1 | Read strobe of the channel register |
| clr_wr | input | 1 | Flag clear strobe |
| clr_data | input | 2 | Bit 0 status flag, bit 1 overcapture; 0 clears |
| reg_q | output | CW | Channel register (capture or compare value) |
| flag | output | 1 | Channel status flag |
| ovc_flag | output | 1 | Overcapture flag |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle and pull the status flag in opposite directions. In input mode these are a capture and a read or clear of the flag. In output mode they are a compare hit (or a wrap hit) and a clear write. Directed steps line up a clear write with an exact compare match. Seeded random stimulus then toggles the input, strobes reads and clears, and varies the count at high rates, so captures collide with reads and clears many times. A bench reference model, written from the requirements, judges every cycle. It expects the flag to stay set on such a collision, and it expects the overcapture flag to be raised when the colliding capture finds the flag already set.

// File: rtl/ccflag_channel.sv
module ccflag_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] arr,
  input  logic [1:0]    cnt_mode,
  input  logic          ovf,
  input  logic          unf,
  input  logic          sig_in,
  input  logic          fall_sel,
  input  logic          in_mode,
  input  logic          ie,
  input  logic          reg_wr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          reg_rd,
  input  logic          clr_wr,
  input  logic [1:0]    clr_data,
  output logic [CW-1:0] reg_q,
  output logic          flag,
  output logic          ovc_flag,
  output logic          irq
);

  localparam logic [1:0] MODE_DOWN = 2'd1;

  logic [2:0] sync_q;
  logic       edge_hit, cap, wrap_hit, match, set_ev, flag_clr, ovc_clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sig_in};

  assign edge_hit = fall_sel ? (sync_q[2] & ~sync_q[1]) : (sync_q[1] & ~sync_q[2]);
  assign cap      = in_mode & edge_hit;
  assign wrap_hit = (reg_q > arr) & ((cnt_mode == MODE_DOWN) ? unf : ovf);
  assign match    = ~in_mode & ((cnt == reg_q) | wrap_hit);
  assign set_ev   = cap | match;
  assign flag_clr = (clr_wr & ~clr_data[0]) | (in_mode & reg_rd);
  assign ovc_clr  = clr_wr & ~clr_data[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_q    <= '0;
      flag     <= 1'b0;
      ovc_flag <= 1'b0;
    end else begin
      if (cap)                    reg_q <= cnt;
      else if (!in_mode && reg_wr) reg_q <= reg_wdata;

      if (set_ev)        flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;

      if (cap && flag)   ovc_flag <= 1'b1;
      else if (ovc_clr)  ovc_flag <= 1'b0;
    end

  assign irq = flag & ie;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (reg_q == $past(cnt)) && flag);

  assert_rd_ignored_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && flag && !clr_wr) |=> flag);

  assert_ovc_input_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && !ovc_flag) |=> !ovc_flag);

  assert_ovc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_flag && !(clr_wr && !clr_data[1])) |=> ovc_flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && clr_wr) |=> flag);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  assert_reg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !cap) |=> $stable(reg_q));

endmodule

// File: tb/ccflag_channel_bench.sv
`timescale 1ns/1ps
module ccflag_channel_bench;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt = '0, arr = '0, wdata = '0;
  logic [1:0] cmode = '0, cdata = 2'b11;
  logic ovf = 0, unf = 0, sig = 0, fsel = 0, imode = 0, ie = 0, wr = 0, rd = 0, cw = 0;
  logic [CW-1:0] reg_q;
  logic flag, ovc_flag, irq;

  int total = 0, bad = 0;
  logic m_s1 = 0, m_s2 = 0, m_s3 = 0, m_flag = 0, m_ovc = 0;
  logic [CW-1:0] m_reg = '0;

  always #10 clk = ~clk;

  ccflag_channel #(.CW(CW)) u_ccflag_channel (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .arr(arr), .cnt_mode(cmode),
    .ovf(ovf), .unf(unf), .sig_in(sig), .fall_sel(fsel), .in_mode(imode),
    .ie(ie), .reg_wr(wr), .reg_wdata(wdata), .reg_rd(rd), .clr_wr(cw),
    .clr_data(cdata), .reg_q(reg_q), .flag(flag), .ovc_flag(ovc_flag), .irq(irq));

  function automatic logic edge_of(logic a, logic b, logic f);
    return f ? (!a && b) : (a && !b);
  endfunction

  task automatic chk(string tag, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "flag", {15'd0, flag}, {15'd0, m_flag});
    chk(tag, "ovc_flag", {15'd0, ovc_flag}, {15'd0, m_ovc});
    chk(tag, "reg_q", reg_q, m_reg);
    chk("R9", "irq", {15'd0, irq}, {15'd0, m_flag & ie});
  endtask

  task automatic step(string tag);
    logic cap, match, nf, no;
    logic [CW-1:0] nr;
    cap   = imode && edge_of(m_s2, m_s3, fsel);
    match = !imode && (cnt == m_reg || (m_reg > arr && (cmode == 2'd1 ? unf : ovf)));
    nf = (cap || match) ? 1'b1 : (((cw && !cdata[0]) || (imode && rd)) ? 1'b0 : m_flag);
    no = (cap && m_flag) ? 1'b1 : ((cw && !cdata[1]) ? 1'b0 : m_ovc);
    nr = cap ? cnt : ((!imode && wr) ? wdata : m_reg);
    @(posedge clk);
    #1;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig;
    m_flag = nf; m_ovc = no; m_reg = nr;
    compare(tag);
  endtask

  task automatic idle();
    ovf = 0; unf = 0; wr = 0; rd = 0; cw = 0; cdata = 2'b11;
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    rst_n = 1'b1;
    run("R1", 2);

    imode = 1; fsel = 0; cnt = 16'h1234;
    run("R2", 3);
    sig = 1; run("R2", 4);
    chk("R2", "captured", reg_q, 16'h1234);
    cnt = 16'h2222; sig = 0; run("R2 opposite edge", 4);
    chk("R2", "no capture on falling", reg_q, 16'h1234);

    fsel = 1; cnt = 16'h3333; sig = 1; run("R2", 3); sig = 0; run("R4", 4);
    chk("R4", "overcapture", {15'd0, ovc_flag}, 16'd1);
    chk("R2", "falling capture", reg_q, 16'h3333);

    rd = 1; step("R3"); idle(); step("R5");
    chk("R3", "read clears", {15'd0, flag}, 16'd0);
    chk("R5", "read keeps ovc", {15'd0, ovc_flag}, 16'd1);

    wr = 1; wdata = 16'h0BAD; step("R10"); idle();
    chk("R10", "write ignored in input", reg_q, 16'h3333);

    sig = 1; run("R2", 2); sig = 0; run("R2", 4);
    cw = 1; cdata = 2'b11; step("R8"); idle();
    chk("R8", "write 1 keeps flag", {15'd0, flag}, 16'd1);
    cw = 1; cdata = 2'b10; step("R8"); idle();
    chk("R8", "clear flag", {15'd0, flag}, 16'd0);
    cw = 1; cdata = 2'b01; step("R5"); idle();
    chk("R5", "clear ovc", {15'd0, ovc_flag}, 16'd0);

    imode = 0; cnt = 16'h0010; arr = 16'h0100;
    wr = 1; wdata = 16'h0020; step("R10"); idle();
    chk("R10", "compare load", reg_q, 16'h0020);
    run("R6", 2);
    chk("R6", "no match", {15'd0, flag}, 16'd0);
    cnt = 16'h0020; step("R6");
    chk("R6", "match", {15'd0, flag}, 16'd1);
    cnt = 16'h0021; rd = 1; step("R3"); idle();
    chk("R3", "read in output keeps", {15'd0, flag}, 16'd1);
    cnt = 16'h0020; cw = 1; cdata = 2'b00; step("R8"); idle();
    chk("R8", "set beats clear", {15'd0, flag}, 16'd1);
    cnt = 16'h0001; cw = 1; cdata = 2'b00; step("R8"); idle();

    sig = 1; run("R4", 3); sig = 0; run("R4", 3);
    chk("R4", "no ovc in output", {15'd0, ovc_flag}, 16'd0);

    wr = 1; wdata = 16'hF000; step("R7"); idle();
    cmode = 0; ovf = 1; step("R7"); idle();
    chk("R7", "up ovf", {15'd0, flag}, 16'd1);
    cw = 1; cdata = 2'b10; step("R7"); idle();
    cmode = 1; ovf = 1; step("R7"); idle();
    chk("R7", "down ignores ovf", {15'd0, flag}, 16'd0);
    unf = 1; step("R7"); idle();
    chk("R7", "down unf", {15'd0, flag}, 16'd1);
    cw = 1; cdata = 2'b10; step("R7"); idle();
    cmode = 2; unf = 1; step("R7"); idle();
    chk("R7", "updown ignores unf", {15'd0, flag}, 16'd0);
    ovf = 1; step("R7"); idle();
    chk("R7", "updown ovf", {15'd0, flag}, 16'd1);
    ie = 1; step("R9");
    chk("R9", "irq on", {15'd0, irq}, 16'd1);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) imode = ~imode;
      if ($urandom_range(0, 99) == 0) fsel = ~fsel;
      if ($urandom_range(0, 2) == 0) sig = ~sig;
      cnt   = CW'($urandom_range(0, 24));
      arr   = CW'($urandom_range(0, 20));
      cmode = 2'($urandom_range(0, 2));
      ovf   = ($urandom_range(0, 7) == 0);
      unf   = ($urandom_range(0, 7) == 0);
      ie    = $urandom_range(0, 1) == 1;
      wr    = ($urandom_range(0, 9) == 0);
      wdata = CW'($urandom_range(0, 24));
      rd    = ($urandom_range(0, 5) == 0);
      cw    = ($urandom_range(0, 5) == 0);
      cdata = 2'($urandom_range(0, 3));
      step("R2/R6 random");
    end
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule